// File: doc/BRIEF.md
# Half-Bridge Fault State Manager

This block is the supervisory controller for one half-bridge gate driver. Each clock it looks at the two switch commands, the logic and floating supply undervoltage flags, the desaturation flags from both channels, an active-low shared fault/shutdown line, an active-low shared sync line and an active-high clear input. It produces the final on/off commands for the high and low switch. Both shared lines are modelled as open-drain: the block gets the sensed level on one port and a pull-low request on another. A low level that the block is not causing itself is treated as coming from outside.

There are eight states. `ST_START` holds both outputs off for `STARTUP_CYCLES` cycles. `ST_RUN` is normal operation. `ST_SOFT` runs for `SOFT_OFF_CYCLES` cycles and pulls the sync line low. `ST_LATCH` pulls the fault line low. `ST_SHDN` is entered when the fault line is pulled from outside. `ST_FREEZE` is entered when the sync line is pulled from outside. `ST_LUV` covers logic-supply undervoltage and `ST_FUV` covers floating-supply undervoltage. The transitions are:
- reset → `ST_START`
- any state → `ST_LUV` on logic undervoltage
- `ST_LUV` → `ST_START` when that flag clears
- `ST_START` → `ST_SOFT` on desat; otherwise to the resolved state once the start-up count expires
- `ST_SOFT` → `ST_LATCH` when its count expires
- `ST_LATCH` → resolved state on a valid clear
- `ST_RUN`/`ST_SHDN`/`ST_FREEZE`/`ST_FUV` → `ST_SOFT` on desat, else → resolved state

The resolved state is the first that applies in this order: `ST_SHDN`, `ST_FREEZE`, `ST_FUV`, `ST_RUN`.

Outputs are registered, so a change at the inputs appears at the outputs one clock later. A latched fault does not survive a logic undervoltage: leaving `ST_LUV` always passes through start-up.

Top module: `hb_fault_mgr`

## Requirements
- R1: After reset, and after logic undervoltage clears, both outputs stay 0 while the block counts `STARTUP_CYCLES` cycles in start-up. After reset release the outputs can first become 1 at the `STARTUP_CYCLES`-th rising edge.
- R2: In normal operation, `hi_on_o` and `lo_on_o` follow `hi_cmd_i` and `lo_cmd_i` one clock later.
- R3: When both commands are 1 in normal operation, both outputs are 0. The two outputs are never 1 together.
- R4: When the fault line reads 0 and `flt_pull_o` is 0 (an outside pull), both outputs are 0 one clock later. This outranks freeze.
- R5: When the sync line reads 0 and `sync_pull_o` is 0, with no higher-priority condition, both outputs keep their current values whatever the commands do.
- R6: While `float_uv_i` is 1, `hi_on_o` is 0 and `lo_on_o` follows `lo_cmd_i`.
- R7: After floating undervoltage ends, `hi_on_o` stays 0 until `hi_cmd_i` makes a new 0→1 transition outside floating undervoltage.
- R8: While `logic_uv_i` is 1, both outputs are 0 one clock later. This outranks every other condition.
- R9: A 1 on `desat_hi_i` or `desat_lo_i` outside undervoltage and fault handling enters soft shutdown at the next edge. For `SOFT_OFF_CYCLES` cycles both outputs are 0 and `sync_pull_o` is 1.
- R10: After soft shutdown the block latches a fault: `flt_pull_o` is 1 and both outputs are 0 until `fault_clr_i` is 1.
- R11: `fault_clr_i` has no effect while either desat flag is 1. The fault stays latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd_i | input | 1 | High switch command |
| lo_cmd_i | input | 1 | Low switch command |
| logic_uv_i | input | 1 | Logic supply undervoltage flag |
| float_uv_i | input | 1 | Floating supply undervoltage flag |
| desat_hi_i | input | 1 | High channel desaturation flag |
| desat_lo_i | input | 1 | Low channel desaturation flag |
| flt_line_i | input | 1 | Sensed level of the shared fault/shutdown line (0 = low) |
| sync_line_i | input | 1 | Sensed level of the shared sync line (0 = low) |
| fault_clr_i | input | 1 | Latched fault clear, active high |
| hi_on_o | output | 1 | Final high switch on command |
| lo_on_o | output | 1 | Final low switch on command |
| flt_pull_o | output | 1 | 1 = pull the fault line low (latched fault) |
| sync_pull_o | output | 1 | 1 = pull the sync line low (soft shutdown) |

## Verification
The bench builds the block with `STARTUP_CYCLES` = 4 and `SOFT_OFF_CYCLES` = 3. With these values the exact cycle on which start-up ends can be checked both after reset and after logic undervoltage. The exact cycle on which soft shutdown hands over to the latched fault can be checked the same way. The short windows also leave room, in one run, for the priority cases: shutdown over freeze, undervoltage over a pulled line, and clear while desat is still active. The high-side re-arm after floating undervoltage is covered in the same run.

// File: rtl/hbfm_pkg.sv
package hbfm_pkg;

    typedef enum logic [2:0] {
        ST_START  = 3'd0,
        ST_RUN    = 3'd1,
        ST_SOFT   = 3'd2,
        ST_LATCH  = 3'd3,
        ST_SHDN   = 3'd4,
        ST_FREEZE = 3'd5,
        ST_LUV    = 3'd6,
        ST_FUV    = 3'd7
    } hbfm_state_e;

endpackage

// File: rtl/hbfm_sense.sv
module hbfm_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd_i,
    input  logic desat_hi_i,
    input  logic desat_lo_i,
    input  logic flt_line_i,
    input  logic flt_pull_i,
    input  logic sync_line_i,
    input  logic sync_pull_i,
    output logic hi_rise_o,
    output logic desat_any_o,
    output logic ext_sd_o,
    output logic ext_freeze_o
);

    logic hi_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_prev_q <= 1'b0;
        end else begin
            hi_prev_q <= hi_cmd_i;
        end
    end

    always_comb begin
        hi_rise_o    = hi_cmd_i && !hi_prev_q;
        desat_any_o  = desat_hi_i || desat_lo_i;
        // a low level counts as external only while this block is not pulling
        ext_sd_o     = !flt_line_i && !flt_pull_i;
        ext_freeze_o = !sync_line_i && !sync_pull_i;
    end

endmodule

// File: rtl/hbfm_timer.sv
module hbfm_timer
    import hbfm_pkg::*;
#(
    parameter int unsigned STARTUP_CYCLES  = 256,
    parameter int unsigned SOFT_OFF_CYCLES = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  hbfm_state_e state_q,
    input  hbfm_state_e state_d,
    output logic        start_done_o,
    output logic        soft_done_o
);

    localparam int unsigned MAX_LEN = (STARTUP_CYCLES > SOFT_OFF_CYCLES) ?
                                      STARTUP_CYCLES : SOFT_OFF_CYCLES;
    localparam int unsigned CW = $clog2(MAX_LEN + 1);
    localparam logic [CW-1:0] START_LAST = CW'(STARTUP_CYCLES - 1);
    localparam logic [CW-1:0] SOFT_LAST  = CW'(SOFT_OFF_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          timed_state;

    always_comb begin
        timed_state = (state_q == ST_START) || (state_q == ST_SOFT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_d != state_q) begin
            cnt_q <= '0;
        end else if (timed_state) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        start_done_o = (state_q == ST_START) && (cnt_q == START_LAST);
        soft_done_o  = (state_q == ST_SOFT)  && (cnt_q == SOFT_LAST);
    end

endmodule

// File: rtl/hbfm_fsm.sv
module hbfm_fsm
    import hbfm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        logic_uv_i,
    input  logic        float_uv_i,
    input  logic        desat_any_i,
    input  logic        ext_sd_i,
    input  logic        ext_freeze_i,
    input  logic        fault_clr_i,
    input  logic        start_done_i,
    input  logic        soft_done_i,
    output hbfm_state_e state_q,
    output hbfm_state_e state_d
);

    hbfm_state_e resolved;

    // lowest tiers of the hierarchy, shared by every exit into operation
    always_comb begin
        if (ext_sd_i) begin
            resolved = ST_SHDN;
        end else if (ext_freeze_i) begin
            resolved = ST_FREEZE;
        end else if (float_uv_i) begin
            resolved = ST_FUV;
        end else begin
            resolved = ST_RUN;
        end
    end

    always_comb begin
        state_d = state_q;
        if (logic_uv_i) begin
            state_d = ST_LUV;
        end else begin
            unique case (state_q)
                ST_LUV: begin
                    state_d = ST_START;
                end
                ST_SOFT: begin
                    state_d = soft_done_i ? ST_LATCH : ST_SOFT;
                end
                ST_LATCH: begin
                    state_d = (fault_clr_i && !desat_any_i) ? resolved : ST_LATCH;
                end
                default: begin
                    if (desat_any_i) begin
                        state_d = ST_SOFT;
                    end else if ((state_q == ST_START) && !start_done_i) begin
                        state_d = ST_START;
                    end else begin
                        state_d = resolved;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_START;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/hbfm_drive.sv
module hbfm_drive
    import hbfm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  hbfm_state_e state_d,
    input  logic        hi_cmd_i,
    input  logic        lo_cmd_i,
    input  logic        hi_rise_i,
    output logic        hi_on_o,
    output logic        lo_on_o
);

    logic armed_q;
    logic armed_d;
    logic hi_d;
    logic lo_d;

    // high side re-arms only on a fresh edge seen outside floating undervoltage
    always_comb begin
        if (state_d == ST_FUV) begin
            armed_d = 1'b0;
        end else if (hi_rise_i) begin
            armed_d = 1'b1;
        end else begin
            armed_d = armed_q;
        end
    end

    always_comb begin
        hi_d = 1'b0;
        lo_d = 1'b0;
        unique case (state_d)
            ST_RUN: begin
                if (!(hi_cmd_i && lo_cmd_i)) begin
                    hi_d = hi_cmd_i && armed_d;
                    lo_d = lo_cmd_i;
                end
            end
            ST_FUV: begin
                lo_d = lo_cmd_i;
            end
            ST_FREEZE: begin
                hi_d = hi_on_o;
                lo_d = lo_on_o;
            end
            default: begin
                hi_d = 1'b0;
                lo_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
            hi_on_o <= 1'b0;
            lo_on_o <= 1'b0;
        end else begin
            armed_q <= armed_d;
            hi_on_o <= hi_d;
            lo_on_o <= lo_d;
        end
    end

endmodule

// File: rtl/hb_fault_mgr.sv
module hb_fault_mgr
    import hbfm_pkg::*;
#(
    parameter int unsigned STARTUP_CYCLES  = 256,
    parameter int unsigned SOFT_OFF_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd_i,
    input  logic lo_cmd_i,
    input  logic logic_uv_i,
    input  logic float_uv_i,
    input  logic desat_hi_i,
    input  logic desat_lo_i,
    input  logic flt_line_i,
    input  logic sync_line_i,
    input  logic fault_clr_i,
    output logic hi_on_o,
    output logic lo_on_o,
    output logic flt_pull_o,
    output logic sync_pull_o
);

    hbfm_state_e state_q;
    hbfm_state_e state_d;
    logic        hi_rise;
    logic        desat_any;
    logic        ext_sd;
    logic        ext_freeze;
    logic        start_done;
    logic        soft_done;

    always_comb begin
        flt_pull_o  = (state_q == ST_LATCH);
        sync_pull_o = (state_q == ST_SOFT);
    end

    hbfm_sense u_sense (
        .clk          (clk),
        .rst_n        (rst_n),
        .hi_cmd_i     (hi_cmd_i),
        .desat_hi_i   (desat_hi_i),
        .desat_lo_i   (desat_lo_i),
        .flt_line_i   (flt_line_i),
        .flt_pull_i   (flt_pull_o),
        .sync_line_i  (sync_line_i),
        .sync_pull_i  (sync_pull_o),
        .hi_rise_o    (hi_rise),
        .desat_any_o  (desat_any),
        .ext_sd_o     (ext_sd),
        .ext_freeze_o (ext_freeze)
    );

    hbfm_timer #(
        .STARTUP_CYCLES  (STARTUP_CYCLES),
        .SOFT_OFF_CYCLES (SOFT_OFF_CYCLES)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_q      (state_q),
        .state_d      (state_d),
        .start_done_o (start_done),
        .soft_done_o  (soft_done)
    );

    hbfm_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .logic_uv_i   (logic_uv_i),
        .float_uv_i   (float_uv_i),
        .desat_any_i  (desat_any),
        .ext_sd_i     (ext_sd),
        .ext_freeze_i (ext_freeze),
        .fault_clr_i  (fault_clr_i),
        .start_done_i (start_done),
        .soft_done_i  (soft_done),
        .state_q      (state_q),
        .state_d      (state_d)
    );

    hbfm_drive u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_d   (state_d),
        .hi_cmd_i  (hi_cmd_i),
        .lo_cmd_i  (lo_cmd_i),
        .hi_rise_i (hi_rise),
        .hi_on_o   (hi_on_o),
        .lo_on_o   (lo_on_o)
    );

endmodule

// File: rtl/hbfm_checker.sv
module hbfm_checker
    import hbfm_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        logic_uv_i,
    input logic        desat_hi_i,
    input logic        desat_lo_i,
    input logic        flt_line_i,
    input logic        sync_line_i,
    input logic        hi_on_o,
    input logic        lo_on_o,
    input logic        flt_pull_o,
    input logic        sync_pull_o,
    input hbfm_state_e state_q
);

    logic desat_any;
    logic pre_fault;
    assign desat_any = desat_hi_i || desat_lo_i;
    assign pre_fault = (state_q != ST_LUV) && (state_q != ST_SOFT) && (state_q != ST_LATCH);

    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_on_o && lo_on_o));

    p_ext_sd_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flt_line_i && !flt_pull_o && !logic_uv_i) |=> (!hi_on_o && !lo_on_o));

    p_freeze_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_line_i && !sync_pull_o && flt_line_i && !logic_uv_i && !desat_any &&
         ((state_q == ST_RUN) || (state_q == ST_FREEZE)))
        |=> ($stable(hi_on_o) && $stable(lo_on_o)));

    p_fuv_hi_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FUV) |-> !hi_on_o);

    p_luv_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        logic_uv_i |=> (!hi_on_o && !lo_on_o));

    p_desat_soft_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (desat_any && !logic_uv_i && pre_fault) |=> sync_pull_o);

    p_soft_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pull_o |-> (!hi_on_o && !lo_on_o && !flt_pull_o));

    p_latch_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flt_pull_o |-> (!hi_on_o && !lo_on_o));

    p_clr_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_pull_o && desat_any && !logic_uv_i) |=> flt_pull_o);

endmodule

bind hb_fault_mgr hbfm_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .logic_uv_i  (logic_uv_i),
    .desat_hi_i  (desat_hi_i),
    .desat_lo_i  (desat_lo_i),
    .flt_line_i  (flt_line_i),
    .sync_line_i (sync_line_i),
    .hi_on_o     (hi_on_o),
    .lo_on_o     (lo_on_o),
    .flt_pull_o  (flt_pull_o),
    .sync_pull_o (sync_pull_o),
    .state_q     (state_q)
);

// File: tb/hb_fault_mgr_test.sv
module hb_fault_mgr_test;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi_cmd = 1'b0, lo_cmd = 1'b0, luv = 1'b0, fuv = 1'b0;
    logic dh = 1'b0, dl = 1'b0, ext_flt = 1'b0, ext_sync = 1'b0, clr = 1'b0;
    logic hi_on, lo_on, flt_pull, sync_pull;
    logic flt_line, sync_line;

    int vectors = 0;
    int miscompares = 0;
    logic [3:0] exp_q[$];
    string      tag_q[$];

    // open-drain lines: low if anyone pulls
    assign flt_line  = ~(flt_pull | ext_flt);
    assign sync_line = ~(sync_pull | ext_sync);

    always #(CLK_PERIOD/2) clk = ~clk;

    hb_fault_mgr #(.STARTUP_CYCLES(4), .SOFT_OFF_CYCLES(3)) uut (
        .clk(clk), .rst_n(rst_n), .hi_cmd_i(hi_cmd), .lo_cmd_i(lo_cmd),
        .logic_uv_i(luv), .float_uv_i(fuv), .desat_hi_i(dh), .desat_lo_i(dl),
        .flt_line_i(flt_line), .sync_line_i(sync_line), .fault_clr_i(clr),
        .hi_on_o(hi_on), .lo_on_o(lo_on), .flt_pull_o(flt_pull), .sync_pull_o(sync_pull)
    );

    function automatic void compare(input logic [3:0] exp, input string tag);
        logic [3:0] act;
        act = {hi_on, lo_on, flt_pull, sync_pull};
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: {hi,lo,fpull,spull} actual %b expected %b", tag, act, exp);
        end
    endfunction

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // driver: one vector per cycle, expected result queued for the monitor
    task automatic step(input logic h, input logic l, input logic u, input logic f,
                        input logic a, input logic b, input logic pf, input logic ps,
                        input logic c, input logic [3:0] exp, input string tag);
        @(negedge clk);
        hi_cmd = h; lo_cmd = l; luv = u; fuv = f; dh = a; dl = b;
        ext_flt = pf; ext_sync = ps; clr = c;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // monitor: compare just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                compare(exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        hi_cmd = 1'b1;
        repeat (3) @(negedge clk);
        compare(4'b0000, "R1 reset state");
        rst_n = 1'b1;
        //    h  l  u  f  dh dl pf ps c   exp
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 4'b0000, "R1 start-up hold a");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 4'b0000, "R1 start-up hold b");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 4'b1000, "R1 start-up end");
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, 4'b0100, "R2 low follows");
        step(1, 1, 0, 0, 0, 0, 0, 0, 0, 4'b0000, "R3 both commands");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 4'b1000, "R2 high follows");
        step(1, 0, 0, 0, 0, 0, 1, 0, 0, 4'b0000, "R4 external shutdown");
        step(0, 1, 0, 0, 0, 0, 1, 0, 0, 4'b0000, "R4 shutdown ignores commands");
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, 4'b0100, "R4 shutdown release");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 4'b1000, "R2 high again");
        step(0, 1, 0, 0, 0, 0, 0, 1, 0, 4'b1000, "R5 freeze hold a");
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 4'b1000, "R5 freeze hold b");
        step(0, 0, 0, 0, 0, 0, 1, 1, 0, 4'b0000, "R4 shutdown outranks freeze");
        step(0, 1, 0, 0, 0, 0, 0, 1, 0, 4'b0000, "R5 freeze holds off");
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, 4'b0100, "R5 freeze release");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 4'b1000, "R2 high before fuv");
        step(1, 0, 0, 1, 0, 0, 0, 0, 0, 4'b0000, "R6 fuv high off");
        step(1, 1, 0, 1, 0, 0, 0, 0, 0, 4'b0100, "R6 fuv low follows");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 4'b0000, "R7 no re-arm without edge");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 4'b0000, "R7 high command drop");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 4'b1000, "R7 re-armed on edge");
        step(1, 0, 1, 0, 0, 0, 0, 0, 0, 4'b0000, "R8 logic uv off");
        step(1, 0, 1, 0, 0, 0, 1, 1, 0, 4'b0000, "R8 uv outranks lines");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 4'b0000, "R1 uv exit start a");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 4'b0000, "R1 uv exit start b");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 4'b0000, "R1 uv exit start c");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 4'b0000, "R1 uv exit start d");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 4'b1000, "R1 uv exit start end");
        step(1, 0, 0, 0, 1, 0, 0, 0, 0, 4'b0001, "R9 desat enters soft");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 4'b0001, "R9 soft b");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 4'b0001, "R9 soft c");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 4'b0010, "R10 fault latched");
        step(1, 0, 0, 0, 0, 1, 0, 0, 1, 4'b0010, "R11 clear with desat ignored");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 4'b0010, "R10 latch holds");
        step(1, 0, 0, 0, 0, 0, 0, 0, 1, 4'b1000, "R10 clear releases");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 4'b1000, "R2 running after clear");
        step(1, 0, 0, 1, 0, 0, 0, 0, 0, 4'b0000, "R6 fuv again");
        step(1, 0, 0, 1, 0, 1, 0, 0, 0, 4'b0001, "R9 low desat from fuv");
        step(1, 0, 0, 1, 0, 0, 0, 0, 0, 4'b0001, "R9 soft from fuv");
        wait (exp_q.size() == 0);
        @(negedge clk);
        report();
    end

endmodule